// File: doc/BRIEF.md
# Page-Table Walker with Accessed/Dirty Write-Back

This block walks a four- or five-level first-stage translation table for one I/O virtual address at a time. Each level costs one 64-bit read from memory. On the way down it marks every visited entry as accessed. On a write request it also marks the final leaf entry as dirty. An entry is written back only when one of those flags actually changes, and the write goes to the same address it was read from.

A request carries the virtual address, a write/read indicator, the depth selector and the root table base. Memory traffic uses a single request channel for both reads and write-backs, with valid/ready. Only one response may be outstanding. When the walk ends, a one-cycle completion pulse reports one of two results:

- the leaf entry, with its flags as updated, and the level it sits at; or
- a fault code and the level where the walk stopped.

Top module: `pt_flag_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `mem_req_valid` is 0 and `done_valid` is 0.
- R2: The top level is 5 when `req_five_level` is 1 and 4 otherwise. At level L the read address is the table base plus 8 times the index. The index is the 9-bit slice of `req_vaddr` starting at bit 12+9*(L-1). The root base is `req_root` with bits 11:0 cleared. A lower table's base is the entry's bits PA_W-1:12 with bits 11:0 cleared.
- R3: An entry ends the walk as a leaf at level 1, or at level 2 or 3 when its bit 7 is set. Bit 7 at level 4 or 5 is ignored and the walk descends.
- R4: Every entry that passes its checks gets bit 5 (accessed) set. A write-back is issued only when the new word differs from the word read.
- R5: Bit 6 (dirty) is set only in the leaf entry and only for write requests. At the leaf, the accessed and dirty updates travel in a single write.
- R6: A write-back is a full 64-bit word (byte 0 in bits 7:0) to the address just read. It differs from the read word only in bits 5 and 6.
- R7: An entry with bit 0 clear ends the walk with fault 0x01. No write is issued at that level.
- R8: On a write request, an entry with bit 1 clear ends the walk with fault 0x02, and no write is issued at that level. Read requests ignore bit 1.
- R9: An error response to a read ends the walk with fault 0x03. An error response to a write-back ends it with fault 0x91.
- R10: `done_valid` pulses for one cycle. On success, `done_ok`=1, `done_fault`=0, `done_entry` is the updated leaf and `done_level` is its level. On a fault, `done_ok`=0, `done_entry`=0 and `done_level` is the faulting level.
- R11: `req_ready` is low while a walk is in progress. A memory request holds its address and type stable until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Walk request valid |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | VA_W | I/O virtual address |
| req_write | input | 1 | 1 for a write access |
| req_five_level | input | 1 | 1 selects a five-level walk |
| req_root | input | PA_W | Root table base |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 for write-back, 0 for read |
| mem_req_addr | output | PA_W | Entry byte address |
| mem_req_wdata | output | 64 | Write-back word |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_err | input | 1 | Memory response error |
| mem_rsp_rdata | input | 64 | Read data |
| done_valid | output | 1 | Walk finished (one cycle) |
| done_ok | output | 1 | Walk succeeded |
| done_fault | output | 8 | Fault code |
| done_level | output | 3 | Level where the walk ended |
| done_entry | output | 64 | Updated leaf entry |

## Verification
At the leaf of a write walk, the accessed and dirty updates coincide and must leave together in one write-back. The stimulus table presets the accessed and dirty bits of the leaf in different combinations and runs write walks across them. The bench then counts the write-backs per walk. It also compares the final word in memory against a word computed from the preset pattern. Three outcomes are distinguished: one write carrying both bits, a write carrying only the dirty bit, or no write at all.

// File: rtl/pt_flag_walker.sv
module pt_flag_walker #(
  parameter int PA_W  = 52,
  parameter int VA_W  = 57,
  parameter int IDX_W = 9,
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  input  logic             req_five_level,
  input  logic [PA_W-1:0]  req_root,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_we,
  output logic [PA_W-1:0]  mem_req_addr,
  output logic [63:0]      mem_req_wdata,
  input  logic             mem_rsp_valid,
  input  logic             mem_rsp_err,
  input  logic [63:0]      mem_rsp_rdata,
  output logic             done_valid,
  output logic             done_ok,
  output logic [7:0]       done_fault,
  output logic [LVL_W-1:0] done_level,
  output logic [63:0]      done_entry
);
  localparam int PG = 12;
  localparam logic [PA_W-1:0] PG_MASK = ~PA_W'((1 << PG) - 1);
  localparam logic [63:0] A_BIT = 64'h20;
  localparam logic [63:0] D_BIT = 64'h40;
  localparam logic [7:0] FLT_NP  = 8'h01;
  localparam logic [7:0] FLT_WP  = 8'h02;
  localparam logic [7:0] FLT_RD  = 8'h03;
  localparam logic [7:0] FLT_UPD = 8'h91;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RSP} st_t;

  st_t              st;
  logic [VA_W-1:0]  va_q;
  logic             wr_q, wb_q, leaf_q;
  logic [LVL_W-1:0] lvl_q;
  logic [PA_W-1:0]  base_q, rd_addr_q;
  logic [63:0]      raw_q, upd_q;

  logic [VA_W-1:0]  va_sh;
  logic [IDX_W-1:0] idx;
  logic [PA_W-1:0]  ent_addr;
  logic             leaf_now, fin, go_wb, adv, nxt_leaf;
  logic [63:0]      upd_now, nxt_entry;
  logic [7:0]       fin_code;

  assign va_sh    = va_q >> (PG + IDX_W * (int'(lvl_q) - 1));
  assign idx      = va_sh[IDX_W-1:0];
  assign ent_addr = base_q + PA_W'({idx, 3'b000});

  assign leaf_now = (lvl_q == LVL_W'(1)) ||
                    (mem_rsp_rdata[7] && (lvl_q == LVL_W'(2) || lvl_q == LVL_W'(3)));
  assign upd_now  = mem_rsp_rdata | A_BIT | ((leaf_now && wr_q) ? D_BIT : 64'h0);

  assign nxt_entry = wb_q ? upd_q : upd_now;
  assign nxt_leaf  = wb_q ? leaf_q : leaf_now;

  always_comb begin
    fin      = 1'b0;
    go_wb    = 1'b0;
    fin_code = 8'h00;
    if (st == ST_RSP && mem_rsp_valid) begin
      if (!wb_q) begin
        if (mem_rsp_err) begin
          fin = 1'b1; fin_code = FLT_RD;
        end else if (!mem_rsp_rdata[0]) begin
          fin = 1'b1; fin_code = FLT_NP;
        end else if (wr_q && !mem_rsp_rdata[1]) begin
          fin = 1'b1; fin_code = FLT_WP;
        end else if (upd_now != mem_rsp_rdata) begin
          go_wb = 1'b1;
        end
      end else if (mem_rsp_err) begin
        fin = 1'b1; fin_code = FLT_UPD;
      end
    end
  end

  assign adv = (st == ST_RSP) && mem_rsp_valid && !fin && !go_wb;

  assign req_ready     = (st == ST_IDLE);
  assign mem_req_valid = (st == ST_REQ);
  assign mem_req_we    = wb_q;
  assign mem_req_addr  = ent_addr;
  assign mem_req_wdata = wb_q ? upd_q : 64'h0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      va_q       <= '0;
      wr_q       <= 1'b0;
      wb_q       <= 1'b0;
      leaf_q     <= 1'b0;
      lvl_q      <= '0;
      base_q     <= '0;
      rd_addr_q  <= '0;
      raw_q      <= '0;
      upd_q      <= '0;
      done_valid <= 1'b0;
      done_ok    <= 1'b0;
      done_fault <= '0;
      done_level <= '0;
      done_entry <= '0;
    end else begin
      done_valid <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          wr_q   <= req_write;
          lvl_q  <= req_five_level ? LVL_W'(5) : LVL_W'(4);
          base_q <= req_root & PG_MASK;
          wb_q   <= 1'b0;
          st     <= ST_REQ;
        end
        ST_REQ: if (mem_req_ready) begin
          if (!wb_q) rd_addr_q <= ent_addr;
          st <= ST_RSP;
        end
        default: begin
          if (mem_rsp_valid && !wb_q) begin
            raw_q  <= mem_rsp_rdata;
            upd_q  <= upd_now;
            leaf_q <= leaf_now;
          end
          if (fin) begin
            done_valid <= 1'b1;
            done_ok    <= 1'b0;
            done_fault <= fin_code;
            done_level <= lvl_q;
            done_entry <= '0;
            st         <= ST_IDLE;
          end else if (go_wb) begin
            wb_q <= 1'b1;
            st   <= ST_REQ;
          end else if (adv) begin
            if (nxt_leaf) begin
              done_valid <= 1'b1;
              done_ok    <= 1'b1;
              done_fault <= 8'h00;
              done_level <= lvl_q;
              done_entry <= nxt_entry;
              st         <= ST_IDLE;
            end else begin
              base_q <= nxt_entry[PA_W-1:0] & PG_MASK;
              lvl_q  <= lvl_q - LVL_W'(1);
              wb_q   <= 1'b0;
              st     <= ST_REQ;
            end
          end
        end
      endcase
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)); // R11
  AST_WB_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> mem_req_addr == rd_addr_q); // R6
  AST_WB_ONLY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> ((mem_req_wdata ^ raw_q) & ~(A_BIT | D_BIT)) == 64'h0); // R6
  AST_WB_CHANGES: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> mem_req_wdata != raw_q && mem_req_wdata[5]); // R4
  AST_DIRTY_LEAF: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we && mem_req_wdata[6] && !raw_q[6] |-> wr_q && leaf_q); // R5
  AST_NP_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> raw_q[0]); // R7
  AST_WP_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we && wr_q |-> raw_q[1]); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid); // R10
  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready); // R11
endmodule

// File: tb/pt_flag_walker_bench.sv
`timescale 1ns/1ps
module pt_flag_walker_bench;
  localparam int PA_W = 52;
  localparam int VA_W = 57;

  typedef struct packed {
    logic       five;
    logic       wr;
    logic [2:0] leaf;
    logic [4:0] pre_a;
    logic       pre_d;
    logic [2:0] np;
    logic [2:0] nowr;
    logic [7:0] fault;
    logic [2:0] lvl;
    logic [2:0] writes;
  } vec_t;

  // R3 R4 R5 R7 R8: five, wr, leaf level, preset A mask (bit L-1), preset D, np level, no-write level, fault, level, writes
  localparam vec_t VECS [13] = '{
    '{1'b0, 1'b0, 3'd1, 5'b00000, 1'b0, 3'd0, 3'd0, 8'h00, 3'd1, 3'd4},
    '{1'b0, 1'b1, 3'd1, 5'b00000, 1'b0, 3'd0, 3'd0, 8'h00, 3'd1, 3'd4},
    '{1'b0, 1'b1, 3'd1, 5'b11111, 1'b0, 3'd0, 3'd0, 8'h00, 3'd1, 3'd1},
    '{1'b0, 1'b1, 3'd1, 5'b11111, 1'b1, 3'd0, 3'd0, 8'h00, 3'd1, 3'd0},
    '{1'b0, 1'b0, 3'd1, 5'b11111, 1'b0, 3'd0, 3'd0, 8'h00, 3'd1, 3'd0},
    '{1'b1, 1'b0, 3'd2, 5'b00000, 1'b0, 3'd0, 3'd0, 8'h00, 3'd2, 3'd4},
    '{1'b1, 1'b1, 3'd3, 5'b00000, 1'b0, 3'd0, 3'd0, 8'h00, 3'd3, 3'd3},
    '{1'b0, 1'b1, 3'd1, 5'b00000, 1'b0, 3'd0, 3'd3, 8'h02, 3'd3, 3'd1},
    '{1'b0, 1'b0, 3'd1, 5'b00000, 1'b0, 3'd0, 3'd3, 8'h00, 3'd1, 3'd4},
    '{1'b0, 1'b0, 3'd1, 5'b00000, 1'b0, 3'd2, 3'd0, 8'h01, 3'd2, 3'd2},
    '{1'b1, 1'b0, 3'd4, 5'b00000, 1'b0, 3'd0, 3'd0, 8'h00, 3'd1, 3'd5},
    '{1'b0, 1'b1, 3'd2, 5'b01010, 1'b0, 3'd0, 3'd0, 8'h00, 3'd2, 3'd2},
    '{1'b0, 1'b1, 3'd1, 5'b00000, 1'b0, 3'd4, 3'd0, 8'h01, 3'd4, 3'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic            req_valid = 1'b0, req_write = 1'b0, req_five_level = 1'b0;
  logic [VA_W-1:0] req_vaddr = '0;
  logic [PA_W-1:0] req_root = '0;
  logic            req_ready, mem_req_valid, mem_req_we, done_valid, done_ok;
  logic            mem_req_ready, mem_rsp_valid, mem_rsp_err;
  logic [PA_W-1:0] mem_req_addr;
  logic [63:0]     mem_req_wdata, mem_rsp_rdata, done_entry;
  logic [7:0]      done_fault;
  logic [2:0]      done_level;

  pt_flag_walker u_pt_flag_walker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_five_level(req_five_level), .req_root(req_root),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err), .mem_rsp_rdata(mem_rsp_rdata),
    .done_valid(done_valid), .done_ok(done_ok), .done_fault(done_fault),
    .done_level(done_level), .done_entry(done_entry)
  );

  logic [63:0] mem [0:4095];
  logic        stall_en = 1'b0, rdy_t = 1'b0;
  logic        err_rd_en = 1'b0, err_wr_en = 1'b0;
  logic [PA_W-1:0] err_rd_addr = '0;
  logic [PA_W-1:0] last_rd;
  int          wr_count = 0, mon_checks = 0, mon_fails = 0;
  int          checks = 0, fails = 0;
  logic [63:0] orig [1:5];

  assign mem_req_ready = !stall_en || rdy_t;

  function automatic logic [63:0] rd_mem(input logic [PA_W-1:0] a);
    return (a[PA_W-1:15] == '0) ? mem[a[14:3]] : 64'h0;
  endfunction

  always @(posedge clk) begin
    rdy_t <= ~rdy_t;
    mem_rsp_valid <= 1'b0;
    mem_rsp_err <= 1'b0;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      if (!mem_req_we) begin
        last_rd = mem_req_addr;
        mem_rsp_err <= err_rd_en && (mem_req_addr == err_rd_addr);
        mem_rsp_rdata <= rd_mem(mem_req_addr);
      end else begin
        wr_count++;
        mon_checks++;
        if (mem_req_addr != last_rd) begin
          mon_fails++;
          $display("FAIL R6 wb addr actual %h expected %h", mem_req_addr, last_rd);
        end
        mon_checks++;
        if (((mem_req_wdata ^ rd_mem(mem_req_addr)) & ~64'h60) != 0 || mem_req_wdata == rd_mem(mem_req_addr)) begin
          mon_fails++;
          $display("FAIL R4 wb data actual %h expected flags-only change of %h", mem_req_wdata, rd_mem(mem_req_addr));
        end
        mem_rsp_err <= err_wr_en;
        if (!err_wr_en && mem_req_addr[PA_W-1:15] == '0) mem[mem_req_addr[14:3]] = mem_req_wdata;
        mem_rsp_rdata <= 64'h0;
      end
    end
  end

  function automatic int idx_of(input int l);
    return 16 * l + 3;
  endfunction

  function automatic logic [PA_W-1:0] ent_addr(input int l);
    return PA_W'(l * 4096 + idx_of(l) * 8);
  endfunction

  function automatic logic [VA_W-1:0] mk_va();
    logic [63:0] v = 64'hABC;
    for (int l = 1; l <= 5; l++) v |= 64'(idx_of(l)) << (12 + 9 * (l - 1));
    return v[VA_W-1:0];
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic build(input vec_t v);
    int top = v.five ? 5 : 4;
    for (int l = 1; l <= 5; l++) begin
      logic [63:0] w = (l == 1) ? 64'h40000 : 64'((l - 1) * 4096);
      w[0] = (v.np != 3'(l));
      w[1] = (v.nowr != 3'(l));
      w[7] = (v.leaf == 3'(l)) && (l != 1);
      w[5] = v.pre_a[l-1];
      w[6] = v.pre_d && (v.leaf == 3'(l));
      orig[l] = w;
      if (l <= top) mem[ent_addr(l)[14:3]] = w;
    end
  endtask

  task automatic walk(input vec_t v);
    @(negedge clk);
    wr_count = 0;
    req_valid = 1'b1; req_write = v.wr; req_five_level = v.five;
    req_vaddr = mk_va(); req_root = PA_W'((v.five ? 5 : 4) * 4096 + 12'h5A5);
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R11 ready low while busy", 64'(req_ready), 64'h0);
    for (int t = 0; t < 200 && !done_valid; t++) @(negedge clk);
    check(done_valid, "R10 done pulse", 64'(done_valid), 64'h1);
    @(negedge clk);
    check(!done_valid, "R10 single-cycle done", 64'(done_valid), 64'h0);
  endtask

  task automatic judge(input vec_t v, input string tag);
    int top = v.five ? 5 : 4;
    bit ok = (v.fault == 8'h00);
    check(u_ok_q == ok, {tag, " ok flag"}, 64'(u_ok_q), 64'(ok));
    check(u_fault_q == v.fault, {tag, " fault code"}, 64'(u_fault_q), 64'(v.fault));
    check(u_level_q == v.lvl, {tag, " R2 level"}, 64'(u_level_q), 64'(v.lvl));
    check(wr_count == int'(v.writes), {tag, " R4 write count"}, 64'(wr_count), 64'(v.writes));
    for (int l = 1; l <= top; l++) begin
      logic [63:0] e = orig[l];
      if (l > v.lvl || (l == v.lvl && ok)) e |= 64'h20;
      if (l == v.lvl && ok && v.wr) e |= 64'h40;
      check(mem[ent_addr(l)[14:3]] == e, {tag, " R5 entry flags"}, mem[ent_addr(l)[14:3]], e);
      if (l == v.lvl && ok)
        check(u_entry_q == e, {tag, " R10 returned entry"}, u_entry_q, e);
    end
  endtask

  logic        u_ok_q;
  logic [7:0]  u_fault_q;
  logic [2:0]  u_level_q;
  logic [63:0] u_entry_q;
  always @(negedge clk) if (done_valid) begin
    u_ok_q = done_ok; u_fault_q = done_fault; u_level_q = done_level; u_entry_q = done_entry;
  end

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks + mon_checks, fails + mon_fails);
    $finish;
  end

  initial begin
    vec_t d;
    for (int i = 0; i < 4096; i++) mem[i] = 64'h0;
    repeat (3) @(negedge clk);
    check(req_ready && !mem_req_valid && !done_valid, "R1 reset state",
          {61'h0, req_ready, mem_req_valid, done_valid}, 64'h4);
    rst_n = 1'b1;

    for (int i = 0; i < 13; i++) begin
      build(VECS[i]);
      walk(VECS[i]);
      judge(VECS[i], $sformatf("R3 R7 R8 vec%0d", i));
    end

    // R9 read error at level 3
    d = '{1'b0, 1'b0, 3'd1, 5'b00000, 1'b0, 3'd0, 3'd0, 8'h03, 3'd3, 3'd1};
    build(d);
    err_rd_en = 1'b1; err_rd_addr = ent_addr(3);
    walk(d);
    judge(d, "R9 read error");
    err_rd_en = 1'b0;

    // R9 write-back error at top level
    d = '{1'b0, 1'b0, 3'd1, 5'b00000, 1'b0, 3'd0, 3'd0, 8'h91, 3'd4, 3'd1};
    build(d);
    err_wr_en = 1'b1;
    walk(d);
    judge(d, "R9 update error");
    err_wr_en = 1'b0;

    // R11 back-pressure on the memory channel
    stall_en = 1'b1;
    build(VECS[1]);
    walk(VECS[1]);
    judge(VECS[1], "R11 stalled");
    stall_en = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", checks + mon_checks, fails + mon_fails);
    $finish;
  end
endmodule